// File: doc/BRIEF.md
# Word and Doubleword Rotate Unit

This block is the rotate slice of the execute stage in a 64-bit RISC core. It looks at a register-type instruction word and, when that word names one of five rotate-right forms, turns the rt operand into the destination write data. Two forms work on a 32-bit word: one rotates by an immediate and one by a register amount. Three forms work on the full 64-bit doubleword: one rotates by an immediate, one by an immediate plus 32, and one by a register amount.

The rotate forms share function-code space with the ordinary shifts. A fixed marker value of 00001 in either the rs field or the sa field sets them apart. When a rotate function code appears with any other marker value, the unit raises an illegal-encoding flag and does not write. Any instruction that is not one of the five rotate function codes under the all-zero major opcode is ignored. The datapath is purely combinational. A parameter selects an optional output register, which is on by default and gives a latency of one cycle.

Top module: `rot_unit`

## Requirements
- R1: A word rotate by immediate is the major opcode instr[31:26]=000000 with rs field instr[25:21]=00001 and function instr[5:0]=000010. It rotates rt[31:0] right by the sa field instr[10:6] and writes the 32-bit result, sign-extended from its bit 31, with wr_en=1.
- R2: A word rotate by register is opcode 000000 with sa field 00001 and function 000110. It rotates rt[31:0] right by rs[4:0], sign-extends the result from bit 31 and sets wr_en=1.
- R3: A doubleword rotate by immediate is opcode 000000 with rs field 00001 and function 111010. It rotates all 64 bits of rt right by sa (0 to 31) and sets wr_en=1.
- R4: A doubleword rotate by immediate plus 32 is opcode 000000 with rs field 00001 and function 111110. It rotates rt right by sa+32 (32 to 63) and sets wr_en=1.
- R5: A doubleword rotate by register is opcode 000000 with sa field 00001 and function 010110. It rotates rt right by rs[5:0] and sets wr_en=1.
- R6: A rotate amount of zero returns the operand unchanged. For the word forms, this means rt[31:0] sign-extended from bit 31.
- R7: When a rotate function code has a marker field other than 00001, illegal=1, wr_en=0 and wr_data=0. This includes function 000010 with rs field 00000. wr_en and illegal are never high together.
- R8: When the opcode is not 000000, or the function is none of the five rotate codes, the outputs are wr_en=0, illegal=0 and wr_data=0.
- R9: Bits of the rs operand above the amount field have no effect on wr_data. For the word form these are rs[63:5]; for the doubleword form they are rs[63:6].
- R10: With OUT_REG=1 (the default), each result appears at the outputs one rising edge after its inputs. While rst_n is low, all outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset for the output register |
| instr | input | 32 | Instruction word |
| rt_val | input | 64 | Source operand to be rotated |
| rs_val | input | 64 | Operand that supplies the register rotate amount |
| wr_data | output | 64 | Destination write data |
| wr_en | output | 1 | Destination write enable |
| illegal | output | 1 | Rotate function code with a bad marker field |

## Verification
With the default output register, every result (wr_data, wr_en and illegal) is due exactly one rising edge after the inputs that produce it. The reset clearing applies on that same edge. The bench therefore changes the inputs on a falling edge and compares all three outputs on the next falling edge, after the single register stage has loaded. The expected values are computed at the moment of driving, from the instruction fields and operands, and are held until that compare.

// File: rtl/rot_pkg.sv
package rot_pkg;
   localparam logic [5:0] OPC_SPECIAL = 6'b000000;
   localparam logic [4:0] ROT_MARK    = 5'b00001;
   localparam logic [5:0] FN_W_IMM    = 6'b000010;
   localparam logic [5:0] FN_W_REG    = 6'b000110;
   localparam logic [5:0] FN_D_IMM    = 6'b111010;
   localparam logic [5:0] FN_D_IMM32  = 6'b111110;
   localparam logic [5:0] FN_D_REG    = 6'b010110;

   typedef enum logic [2:0] {
      RK_NONE   = 3'd0,
      RK_W_IMM  = 3'd1,
      RK_W_REG  = 3'd2,
      RK_D_IMM  = 3'd3,
      RK_D_IMM32= 3'd4,
      RK_D_REG  = 3'd5
   } rot_kind_e;

   typedef struct packed {
      rot_kind_e  kind;
      logic       bad;
      logic [4:0] sa;
   } rot_dec_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
   import rot_pkg::*;
(
   input  logic [31:0] instr,
   output rot_dec_t    dec
);
   logic [5:0] opc, fn;
   logic [4:0] rsf, saf;
   logic       is_rot, mark_ok;
   rot_kind_e  k;

   assign opc = instr[31:26];
   assign rsf = instr[25:21];
   assign saf = instr[10:6];
   assign fn  = instr[5:0];

   always_comb begin
      k       = RK_NONE;
      is_rot  = 1'b0;
      mark_ok = 1'b0;
      if (opc == OPC_SPECIAL) begin
         unique case (fn)
            FN_W_IMM:   begin is_rot = 1'b1; mark_ok = (rsf == ROT_MARK); k = RK_W_IMM;   end
            FN_W_REG:   begin is_rot = 1'b1; mark_ok = (saf == ROT_MARK); k = RK_W_REG;   end
            FN_D_IMM:   begin is_rot = 1'b1; mark_ok = (rsf == ROT_MARK); k = RK_D_IMM;   end
            FN_D_IMM32: begin is_rot = 1'b1; mark_ok = (rsf == ROT_MARK); k = RK_D_IMM32; end
            FN_D_REG:   begin is_rot = 1'b1; mark_ok = (saf == ROT_MARK); k = RK_D_REG;   end
            default:    begin is_rot = 1'b0; mark_ok = 1'b0; k = RK_NONE; end
         endcase
      end
      dec.kind = (is_rot && mark_ok) ? k : RK_NONE;
      dec.bad  = is_rot && !mark_ok;
      dec.sa   = saf;
   end
endmodule

// File: rtl/rot_core.sv
module rot_core #(
   parameter int W = 64
) (
   input  logic [W-1:0]         din,
   input  logic [$clog2(W)-1:0] amt,
   output logic [W-1:0]         dout
);
   localparam int AW = $clog2(W);

   initial begin
      if (W < 2 || (1 << AW) != W)
         $error("rot_core: W must be a power of two of at least 2");
   end

   logic [2*W-1:0] dbl;
   assign dbl  = {din, din} >> amt;
   assign dout = dbl[W-1:0];
endmodule

// File: rtl/rot_unit.sv
module rot_unit
   import rot_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] rt_val,
   input  logic [XLEN-1:0] rs_val,
   output logic [XLEN-1:0] wr_data,
   output logic            wr_en,
   output logic            illegal
);
   localparam int HALF = XLEN / 2;
   localparam int WAW  = $clog2(HALF);
   localparam int DAW  = $clog2(XLEN);

   initial begin
      if (XLEN != 64)
         $error("rot_unit: instruction fields assume XLEN of 64");
      if (WAW != 5)
         $error("rot_unit: word amount must be five bits");
   end

   rot_dec_t        dec;
   logic [WAW-1:0]  w_amt;
   logic [DAW-1:0]  d_amt;
   logic [HALF-1:0] w_rot;
   logic [XLEN-1:0] d_rot;
   logic [XLEN-1:0] w_ext;
   logic [XLEN-1:0] nxt_data;
   logic            nxt_en, nxt_ill, is_word;

   rot_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   assign is_word = (dec.kind == RK_W_IMM) || (dec.kind == RK_W_REG);

   always_comb begin
      w_amt = (dec.kind == RK_W_REG) ? rs_val[WAW-1:0] : dec.sa;
      unique case (dec.kind)
         RK_D_REG:   d_amt = rs_val[DAW-1:0];
         RK_D_IMM32: d_amt = DAW'(dec.sa) + DAW'(HALF);
         default:    d_amt = DAW'(dec.sa);
      endcase
   end

   rot_core #(.W(HALF)) u_wrot (
      .din  (rt_val[HALF-1:0]),
      .amt  (w_amt),
      .dout (w_rot)
   );

   rot_core #(.W(XLEN)) u_drot (
      .din  (rt_val),
      .amt  (d_amt),
      .dout (d_rot)
   );

   assign w_ext = {{HALF{w_rot[HALF-1]}}, w_rot};

   always_comb begin
      nxt_en   = dec.kind != RK_NONE;
      nxt_ill  = dec.bad;
      nxt_data = '0;
      if (nxt_en) nxt_data = is_word ? w_ext : d_rot;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_data <= '0;
               wr_en   <= 1'b0;
               illegal <= 1'b0;
            end else begin
               wr_data <= nxt_data;
               wr_en   <= nxt_en;
               illegal <= nxt_ill;
            end
         end
      end else begin : g_comb
         assign wr_data = nxt_data;
         assign wr_en   = nxt_en;
         assign illegal = nxt_ill;
      end
   endgenerate

   assert_no_dual_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && illegal));

   assert_quiet_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (wr_data == '0));

   assert_word_sext_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_word |-> (nxt_data[XLEN-1:HALF] == {HALF{w_rot[HALF-1]}}));

   assert_dword_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_en && !is_word) |-> ($countones(d_rot) == $countones(rt_val)));

   assert_zero_amt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_en && !is_word && d_amt == '0) |-> (nxt_data == rt_val));
endmodule

// File: tb/rot_unit_tb.sv
module rot_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] rt_val = '0, rs_val = '0;
   logic [63:0] wr_data;
   logic        wr_en, illegal;
   int          n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rot_unit u_dut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .rt_val(rt_val), .rs_val(rs_val),
      .wr_data(wr_data), .wr_en(wr_en), .illegal(illegal)
   );

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rsf,
      input logic [4:0] saf, input logic [5:0] fn);
      return {op, rsf, 5'd7, 5'd9, saf, fn};
   endfunction

   function automatic logic [63:0] rref(input logic [63:0] v, input int amt, input int w);
      logic [63:0] r = '0;
      for (int i = 0; i < w; i++) r[i] = v[(i + amt) % w];
      if (w == 32) r[63:32] = {32{r[31]}};
      return r;
   endfunction

   function automatic void model(input logic [31:0] ins, input logic [63:0] rt,
      input logic [63:0] rs, output logic [63:0] d, output logic en, output logic ill);
      logic [4:0] mark;
      int amt, w;
      logic hit;
      d = '0; en = 0; ill = 0; hit = 1; mark = 0; amt = 0; w = 64;
      if (ins[31:26] != 6'd0) hit = 0;
      else case (ins[5:0])
         6'b000010: begin mark = ins[25:21]; w = 32; amt = int'(ins[10:6]); end
         6'b000110: begin mark = ins[10:6];  w = 32; amt = int'(rs[4:0]);   end
         6'b111010: begin mark = ins[25:21]; amt = int'(ins[10:6]);         end
         6'b111110: begin mark = ins[25:21]; amt = int'(ins[10:6]) + 32;    end
         6'b010110: begin mark = ins[10:6];  amt = int'(rs[5:0]);           end
         default:   hit = 0;
      endcase
      if (hit && mark != 5'b00001) ill = 1;
      else if (hit) begin en = 1; d = rref(rt, amt, w); end
   endfunction

   task automatic cmp(input string tag, input logic [63:0] ed, input logic ee, input logic ei);
      n_chk++;
      if (wr_data !== ed || wr_en !== ee || illegal !== ei) begin
         n_bad++;
         $display("FAIL %s: got data=%h en=%b ill=%b exp data=%h en=%b ill=%b",
                  tag, wr_data, wr_en, illegal, ed, ee, ei);
      end
   endtask

   task automatic run(input string tag, input logic [31:0] ins, input logic [63:0] rt,
      input logic [63:0] rs);
      logic [63:0] ed; logic ee, ei;
      @(negedge clk);
      instr = ins; rt_val = rt; rs_val = rs;
      model(ins, rt, rs, ed, ee, ei);
      @(negedge clk);
      cmp(tag, ed, ee, ei);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] a, b, d1, d2;
      logic e1, i1;
      void'($urandom(32'd1234));
      // R10 reset state with a valid rotate on the inputs
      instr = mk(6'd0, 5'd1, 5'd4, 6'b111010); rt_val = 64'h1; rs_val = '0;
      repeat (3) @(negedge clk);
      cmp("R10 reset", 64'd0, 1'b0, 1'b0);
      rst_n = 1'b1;

      a = 64'hF0E1_D2C3_8000_0001;
      run("R1 word imm", mk(6'd0, 5'd1, 5'd1, 6'b000010), a, '0);
      n_chk++;
      if (wr_data !== 64'hFFFF_FFFF_C000_0000) begin
         n_bad++; $display("FAIL R1 literal: got %h exp %h", wr_data, 64'hFFFF_FFFF_C000_0000);
      end
      run("R2 word reg", mk(6'd0, 5'd0, 5'd1, 6'b000110), a, 64'd4);
      run("R3 dword imm 31", mk(6'd0, 5'd1, 5'd31, 6'b111010), a, '0);
      run("R4 dword imm32 sa31", mk(6'd0, 5'd1, 5'd31, 6'b111110), a, '0);
      n_chk++;
      if (wr_data !== {a[62:0], a[63]}) begin
         n_bad++; $display("FAIL R4 rot63: got %h exp %h", wr_data, {a[62:0], a[63]});
      end
      run("R4 dword imm32 sa0", mk(6'd0, 5'd1, 5'd0, 6'b111110), a, '0);
      run("R5 dword reg", mk(6'd0, 5'd0, 5'd1, 6'b010110), a, 64'd45);
      run("R6 word zero", mk(6'd0, 5'd1, 5'd0, 6'b000010), 64'h1234_5678_8765_4321, '0);
      n_chk++;
      if (wr_data !== 64'hFFFF_FFFF_8765_4321) begin
         n_bad++; $display("FAIL R6 word zero: got %h exp %h", wr_data, 64'hFFFF_FFFF_8765_4321);
      end
      run("R6 dword zero", mk(6'd0, 5'd1, 5'd0, 6'b111010), a, '0);
      run("R6 dword reg zero", mk(6'd0, 5'd0, 5'd1, 6'b010110), a, 64'hFFFF_FFFF_FFFF_FFC0);
      run("R7 srl-like rs0", mk(6'd0, 5'd0, 5'd3, 6'b000010), a, '0);
      run("R7 word reg sa2", mk(6'd0, 5'd0, 5'd2, 6'b000110), a, 64'd3);
      run("R7 dword imm rs3", mk(6'd0, 5'd3, 5'd3, 6'b111010), a, '0);
      run("R7 imm32 rs0", mk(6'd0, 5'd0, 5'd3, 6'b111110), a, '0);
      run("R7 dword reg sa0", mk(6'd0, 5'd0, 5'd0, 6'b010110), a, 64'd3);
      run("R8 opcode", mk(6'd8, 5'd1, 5'd3, 6'b111010), a, '0);
      run("R8 other funct", mk(6'd0, 5'd1, 5'd3, 6'b100001), a, '0);

      // R9 upper rs bits must not change the result
      b = 64'h0123_4567_89AB_CDEF;
      run("R9 word base", mk(6'd0, 5'd0, 5'd1, 6'b000110), b, 64'd9);
      d1 = wr_data;
      run("R9 word high rs", mk(6'd0, 5'd0, 5'd1, 6'b000110), b, 64'hFFFF_FFFF_FFFF_FFE9);
      n_chk++;
      if (wr_data !== d1) begin n_bad++; $display("FAIL R9 word: got %h exp %h", wr_data, d1); end
      run("R9 dword base", mk(6'd0, 5'd0, 5'd1, 6'b010110), b, 64'd37);
      d1 = wr_data;
      run("R9 dword high rs", mk(6'd0, 5'd0, 5'd1, 6'b010110), b, 64'hABCD_0000_0000_00E5);
      n_chk++;
      if (wr_data !== d1) begin n_bad++; $display("FAIL R9 dword: got %h exp %h", wr_data, d1); end

      // R10 one-cycle latency: output still holds previous result before the edge
      @(negedge clk);
      instr = mk(6'd0, 5'd1, 5'd8, 6'b111010); rt_val = b; rs_val = '0;
      model(instr, b, '0, d2, e1, i1);
      #1;
      cmp("R10 latency hold", d1, 1'b1, 1'b0);
      @(negedge clk);
      cmp("R10 latency load", d2, e1, i1);

      for (int it = 0; it < 600; it++) begin
         logic [5:0] fns [5];
         logic [31:0] ins;
         int pick;
         fns[0] = 6'b000010; fns[1] = 6'b000110; fns[2] = 6'b111010;
         fns[3] = 6'b111110; fns[4] = 6'b010110;
         pick = int'($urandom % 5);
         ins = $urandom;
         ins[31:26] = ($urandom % 16 == 0) ? 6'd2 : 6'd0;
         ins[5:0] = fns[pick];
         if ($urandom % 8 != 0) begin
            if (pick == 1 || pick == 4) ins[10:6] = 5'd1; else ins[25:21] = 5'd1;
         end
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         case (pick)
            0: run("R1 random", ins, a, b);
            1: run("R2 random", ins, a, b);
            2: run("R3 random", ins, a, b);
            3: run("R4 random", ins, a, b);
            default: run("R5 random", ins, a, b);
         endcase
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule